// File: doc/BRIEF.md
# Alarm Clock Timekeeping Core

This block keeps a 24-hour time of day as BCD hours, minutes and seconds. A built-in prescaler divides the system clock by `CLK_HZ` to make a one-cycle tick once per second. A separately stored alarm time (hours and minutes) sits beside the running time. Both the current time and the alarm time are changed through the same set procedure. A two-bit mode input chooses running, setting the time or setting the alarm. A field-select input picks hours or minutes, and a one-cycle increment pulse steps the selected field.

Two ring sources drive the single `ring_o` output, which feeds an LED. Each source has its own enable. The hourly chime rings for `CHIME_SECS` seconds when the running clock rolls into a new hour. The alarm rings for `ALARM_SECS` seconds when the running clock reaches the stored alarm hour and minute at second 00. The block has no data stream, so it has no valid/ready interface: every pin is a plain level or a one-cycle pulse, and nothing at the edge applies back-pressure.

Top module: `alarm_clock_core`

## Requirements
- R1: After reset, the time reads 00:00:00, the alarm reads 00:00 and `ring_o` is low.
- R2: A tick occurs once every `CLK_HZ` clock cycles. The first tick comes in cycle `CLK_HZ` after reset. In run mode each tick advances the seconds by one in the same clock edge.
- R3: Each output field is two BCD digits, tens in bits [7:4] and units in bits [3:0]. Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, and each wrap carries into the next field.
- R4: In set-time mode (`mode_i` = 2'b01), ticks do not advance the clock and the seconds read 00 from the next cycle on. Each `inc_i` pulse steps the selected field by one: `sel_hours_i` = 1 selects hours (modulo 24) and 0 selects minutes (modulo 60). The step does not carry into another field.
- R5: In set-alarm mode (`mode_i` = 2'b10), each `inc_i` pulse steps the selected alarm field in the same way, while the clock keeps running. In any other mode the alarm fields do not change.
- R6: `mode_i` values 2'b00 and 2'b11 are both run mode, and in run mode `inc_i` has no effect.
- R7: With `chime_en_i` high, a tick that moves the clock to mm:ss = 00:00 raises `ring_o` from the following cycle, and the ring lasts `CHIME_SECS` ticks.
- R8: With `alarm_en_i` high, a tick that moves the clock to the alarm hour and minute with seconds 00 raises `ring_o` from the following cycle, and the ring lasts `ALARM_SECS` ticks.
- R9: When a chime and an alarm overlap, `ring_o` stays high until the longer of the two remaining durations has expired.
- R10: Driving `alarm_en_i` low ends an alarm ring on the next clock edge. A chime ring is not affected.
- R11: Reaching a matching time through the set procedure never starts a ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00/11 run, 01 set time, 10 set alarm |
| sel_hours_i | input | 1 | Field select for set: 1 hours, 0 minutes |
| inc_i | input | 1 | One-cycle pulse that steps the selected field |
| chime_en_i | input | 1 | Hourly chime enable |
| alarm_en_i | input | 1 | Alarm enable; low cancels an active alarm ring |
| hours_o | output | 8 | Current hours, BCD |
| mins_o | output | 8 | Current minutes, BCD |
| secs_o | output | 8 | Current seconds, BCD |
| alm_hours_o | output | 8 | Alarm hours, BCD |
| alm_mins_o | output | 8 | Alarm minutes, BCD |
| ring_o | output | 1 | LED ring indication |

## Verification
Time fields change on the same edge where the tick is high, and set steps show on the edge that samples `inc_i`. A ring starts one cycle after the clock shows the event time, because the advance is registered before the match. It stops one cycle after the last counting tick, or one cycle after `alarm_en_i` falls. A behavioural model in the bench applies these same latencies on every rising edge. The bench then compares each output against the model at the following falling edge, and measures ring lengths in cycles against `seconds * CLK_HZ - 1`.

// File: rtl/alarm_clk_pkg.sv
package alarm_clk_pkg;
  typedef enum logic [1:0] {
    MODE_RUN       = 2'b00,
    MODE_SET_TIME  = 2'b01,
    MODE_SET_ALARM = 2'b10,
    MODE_RUN_ALT   = 2'b11
  } acc_mode_e;

  typedef logic [7:0] bcd2_t;

  // Step a two-digit BCD value, wrapping to 00 after lim.
  function automatic bcd2_t bcd_step(input bcd2_t v, input bcd2_t lim);
    if (v == lim)             return 8'h00;
    else if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/acc_tick_gen.sv
module acc_tick_gen #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick_o = (cnt == LAST);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/acc_time_keeper.sv
module acc_time_keeper
  import alarm_clk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  set_i,
  input  logic  sel_hours_i,
  input  logic  inc_i,
  output bcd2_t hours_o,
  output bcd2_t mins_o,
  output bcd2_t secs_o
);
  logic sec_wrap, min_wrap;
  assign sec_wrap = (secs_o == 8'h59);
  assign min_wrap = sec_wrap && (mins_o == 8'h59);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hours_o <= 8'h00;
      mins_o  <= 8'h00;
      secs_o  <= 8'h00;
    end else if (set_i) begin
      secs_o <= 8'h00;
      if (inc_i) begin
        if (sel_hours_i) hours_o <= bcd_step(hours_o, 8'h23);
        else             mins_o  <= bcd_step(mins_o, 8'h59);
      end
    end else if (tick_i) begin
      secs_o <= bcd_step(secs_o, 8'h59);
      if (sec_wrap) mins_o  <= bcd_step(mins_o, 8'h59);
      if (min_wrap) hours_o <= bcd_step(hours_o, 8'h23);
    end
  end

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !inc_i) |=> ($stable(hours_o) && $stable(mins_o)));
  a_r4_secs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (secs_o == 8'h00));
  a_r3_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    (secs_o <= 8'h59) && (mins_o <= 8'h59) && (hours_o <= 8'h23) &&
    (secs_o[3:0] <= 4'd9) && (mins_o[3:0] <= 4'd9) && (hours_o[3:0] <= 4'd9));
endmodule

// File: rtl/acc_alarm_store.sv
module acc_alarm_store
  import alarm_clk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_i,
  input  logic  sel_hours_i,
  input  logic  inc_i,
  output bcd2_t alm_hours_o,
  output bcd2_t alm_mins_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_hours_o <= 8'h00;
      alm_mins_o  <= 8'h00;
    end else if (set_i && inc_i) begin
      if (sel_hours_i) alm_hours_o <= bcd_step(alm_hours_o, 8'h23);
      else             alm_mins_o  <= bcd_step(alm_mins_o, 8'h59);
    end
  end

  a_r5_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> ($stable(alm_hours_o) && $stable(alm_mins_o)));
endmodule

// File: rtl/acc_ring_ctrl.sv
module acc_ring_ctrl
  import alarm_clk_pkg::*;
#(
  parameter int CHIME_SECS = 1,
  parameter int ALARM_SECS = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  adv_i,
  input  logic  chime_en_i,
  input  logic  alarm_en_i,
  input  bcd2_t hours_i,
  input  bcd2_t mins_i,
  input  bcd2_t secs_i,
  input  bcd2_t alm_hours_i,
  input  bcd2_t alm_mins_i,
  output logic  ring_o
);
  localparam int CCW = $clog2(CHIME_SECS + 1);
  localparam int ACW = $clog2(ALARM_SECS + 1);

  logic           adv_d;
  logic [CCW-1:0] chime_cnt;
  logic [ACW-1:0] alarm_cnt;
  logic           hour_hit, alarm_hit;

  // Only a real clock advance, seen one cycle later, may start a ring.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_d <= 1'b0;
    else        adv_d <= adv_i;
  end

  assign hour_hit  = adv_d && (mins_i == 8'h00) && (secs_i == 8'h00);
  assign alarm_hit = adv_d && (secs_i == 8'h00) &&
                     (hours_i == alm_hours_i) && (mins_i == alm_mins_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          chime_cnt <= '0;
    else if (hour_hit && chime_en_i)     chime_cnt <= CCW'(CHIME_SECS);
    else if (tick_i && chime_cnt != '0)  chime_cnt <= chime_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          alarm_cnt <= '0;
    else if (!alarm_en_i)                alarm_cnt <= '0;
    else if (alarm_hit)                  alarm_cnt <= ACW'(ALARM_SECS);
    else if (tick_i && alarm_cnt != '0)  alarm_cnt <= alarm_cnt - 1'b1;
  end

  assign ring_o = (chime_cnt != '0) || (alarm_cnt != '0);

  a_r7_chime_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_hit && chime_en_i) |=> ring_o);
  a_r8_alarm_start: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && alarm_en_i) |=> ring_o);
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en_i |=> (alarm_cnt == '0));
  a_r11_no_ring_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_d && !ring_o) |=> !ring_o);
endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core
  import alarm_clk_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int CHIME_SECS = 1,
  parameter int ALARM_SECS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       sel_hours_i,
  input  logic       inc_i,
  input  logic       chime_en_i,
  input  logic       alarm_en_i,
  output logic [7:0] hours_o,
  output logic [7:0] mins_o,
  output logic [7:0] secs_o,
  output logic [7:0] alm_hours_o,
  output logic [7:0] alm_mins_o,
  output logic       ring_o
);
  acc_mode_e mode;
  logic      tick, set_time, set_alarm;

  assign mode      = acc_mode_e'(mode_i);
  assign set_time  = (mode == MODE_SET_TIME);
  assign set_alarm = (mode == MODE_SET_ALARM);

  acc_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  acc_time_keeper u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .set_i(set_time),
    .sel_hours_i(sel_hours_i), .inc_i(inc_i),
    .hours_o(hours_o), .mins_o(mins_o), .secs_o(secs_o)
  );

  acc_alarm_store u_alarm (
    .clk(clk), .rst_n(rst_n), .set_i(set_alarm),
    .sel_hours_i(sel_hours_i), .inc_i(inc_i),
    .alm_hours_o(alm_hours_o), .alm_mins_o(alm_mins_o)
  );

  acc_ring_ctrl #(.CHIME_SECS(CHIME_SECS), .ALARM_SECS(ALARM_SECS)) u_ring (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .adv_i(tick && !set_time),
    .chime_en_i(chime_en_i), .alarm_en_i(alarm_en_i),
    .hours_i(hours_o), .mins_i(mins_o), .secs_i(secs_o),
    .alm_hours_i(alm_hours_o), .alm_mins_i(alm_mins_o),
    .ring_o(ring_o)
  );
endmodule

// File: tb/alarm_clock_core_test.sv
`timescale 1ns/1ps
module alarm_clock_core_test;
  localparam int HZ = 4;
  localparam int CH = 1;
  localparam int AL = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sel_h = 1'b0, inc = 1'b0, chime_en = 1'b0, alarm_en = 1'b0;
  logic [7:0] hours, mins, secs, ah, am;
  logic ring;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  alarm_clock_core #(.CLK_HZ(HZ), .CHIME_SECS(CH), .ALARM_SECS(AL)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sel_hours_i(sel_h), .inc_i(inc),
    .chime_en_i(chime_en), .alarm_en_i(alarm_en),
    .hours_o(hours), .mins_o(mins), .secs_o(secs),
    .alm_hours_o(ah), .alm_mins_o(am), .ring_o(ring)
  );

  // Behavioural reference model
  int m_pc, m_h, m_m, m_s, m_ah, m_am, m_cc, m_ac;
  bit m_adv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_h = 0; m_m = 0; m_s = 0; m_ah = 0; m_am = 0;
      m_cc = 0; m_ac = 0; m_adv = 0;
    end else begin
      bit tk;
      tk = (m_pc == HZ - 1);
      m_pc = tk ? 0 : m_pc + 1;
      if (m_adv && chime_en && m_m == 0 && m_s == 0) m_cc = CH;
      else if (tk && m_cc > 0) m_cc--;
      if (!alarm_en) m_ac = 0;
      else if (m_adv && m_s == 0 && m_h == m_ah && m_m == m_am) m_ac = AL;
      else if (tk && m_ac > 0) m_ac--;
      m_adv = tk && (mode != 2'b01);
      if (mode == 2'b01) begin
        m_s = 0;
        if (inc) begin
          if (sel_h) m_h = (m_h + 1) % 24; else m_m = (m_m + 1) % 60;
        end
      end else if (tk) begin
        m_s++;
        if (m_s == 60) begin
          m_s = 0; m_m++;
          if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; end
        end
      end
      if (mode == 2'b10 && inc) begin
        if (sel_h) m_ah = (m_ah + 1) % 24; else m_am = (m_am + 1) % 60;
      end
    end
  end

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Compare everything against the model at every falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 secs", secs, bcd(m_s));
      chk("R3 mins", mins, bcd(m_m));
      chk("R3 hours", hours, bcd(m_h));
      chk("R5 alarm hours", ah, bcd(m_ah));
      chk("R5 alarm mins", am, bcd(m_am));
      chk("R9 ring", ring, (m_cc > 0 || m_ac > 0) ? 1 : 0);
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic pulse();
    @(negedge clk); inc = 1'b1;
    @(negedge clk); inc = 1'b0;
  endtask

  task automatic set_field(logic [1:0] md, bit hrs, int target);
    @(negedge clk); mode = md; sel_h = hrs;
    for (int i = 0; i < 60; i++) begin
      if (md == 2'b01 && (hrs ? m_h : m_m) == target) break;
      if (md == 2'b10 && (hrs ? m_ah : m_am) == target) break;
      pulse();
    end
  endtask

  task automatic wait_time(int h, int m, int s);
    while (!(m_h == h && m_m == m && m_s == s)) @(negedge clk);
  endtask

  task automatic ring_len(output int len);
    len = 0;
    while (!ring) @(negedge clk);
    while (ring) begin len++; @(negedge clk); end
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk("R1 hours", hours, 8'h00); chk("R1 secs", secs, 8'h00);
    chk("R1 alarm", {ah, am}, 16'h0000); chk("R1 ring", ring, 0);
    rst_n = 1'b1;

    // R2: first tick in cycle HZ after reset
    repeat (HZ - 1) @(negedge clk);
    chk("R2 before tick", secs, 8'h00);
    @(negedge clk);
    chk("R2 after tick", secs, 8'h01);
    repeat (3 * HZ) @(negedge clk);
    chk("R2 three more secs", secs, 8'h04);

    // R4: set time 23:59, minutes wrap without carry
    chime_en = 1'b1;
    set_field(2'b01, 1'b1, 23);
    set_field(2'b01, 1'b0, 59);
    @(negedge clk);
    chk("R4 secs cleared", secs, 8'h00);
    repeat (3 * HZ) @(negedge clk);
    chk("R4 held", {hours, mins, secs}, 24'h235900);
    pulse();
    chk("R4 min wrap no carry", {hours, mins}, 16'h2300);
    pulse(); chk("R4 step", mins, 8'h01);
    set_field(2'b01, 1'b0, 59);

    // R3 + R7: midnight rollover with chime
    @(negedge clk); mode = 2'b00;
    ring_len(len);
    chk("R3 day wrap", {hours, mins}, 16'h0000);
    chk("R7 chime length", len, CH * HZ - 1);

    // R6: inc ignored in run modes
    sel_h = 1'b0; pulse();
    chk("R6 inc ignored", mins, 8'h00);
    mode = 2'b11; pulse();
    chk("R6 alt run ignores inc", mins, 8'h00);

    // R5: set alarm 00:02 while running, mode 11 back to run
    set_field(2'b10, 1'b0, 2);
    chk("R5 alarm set", {ah, am}, 16'h0002);
    @(negedge clk); mode = 2'b11; alarm_en = 1'b1;
    ring_len(len);
    chk("R8 alarm length", len, AL * HZ - 1);

    // R9: alarm at 01:00 overlaps chime
    set_field(2'b10, 1'b1, 1);
    set_field(2'b10, 1'b0, 0);
    set_field(2'b01, 1'b0, 59);
    @(negedge clk); mode = 2'b00;
    ring_len(len);
    chk("R9 overlap length", len, AL * HZ - 1);

    // R10: cancel an alarm ring at 01:02
    set_field(2'b10, 1'b0, 2);
    set_field(2'b01, 1'b0, 1);
    @(negedge clk); mode = 2'b00;
    while (!ring) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R10 ringing before cancel", ring, 1);
    alarm_en = 1'b0;
    @(negedge clk);
    chk("R10 cancelled", ring, 0);

    // R11: setting time onto alarm value does not ring
    alarm_en = 1'b1;
    set_field(2'b01, 1'b0, 2);
    repeat (2 * HZ) @(negedge clk);
    chk("R11 no ring in set", ring, 0);
    @(negedge clk); mode = 2'b00;
    repeat (3 * HZ) @(negedge clk);
    chk("R11 no ring after set", ring, 0);
    chk("R11 time", {hours, mins, secs}, 24'h010203);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule